// File: doc/BRIEF.md
# PWM Event-Trigger Interrupt Prescaler

This block watches the status of a PWM time-base counter, picks one kind of event from it, and counts how often that event occurs. Once a programmable number of events has been counted, it issues a one-cycle interrupt pulse and sets a sticky flag. Software clears the flag with a strobe. While the flag is set, a further completed count is held pending. It then fires as soon as the flag is cleared, so one interrupt can wait while another is being serviced.

The event can be the counter reaching zero, reaching the period, either of these, or matching one of four compare values while the counter runs in one given direction. The event counter saturates at the programmed period and never wraps. It clears only when a pulse is actually issued, or when software writes a period larger than the current count. Two period formats exist. One is a 2-bit field (interrupt on every 1st to 3rd event). The other is a 4-bit field (every 1st to 15th event). A mode bit picks between them.

Top module: `etrig_irq_prescaler`

## Requirements
- R1: While `rst_n` is low and right after it is released, `irq_pulse` is 0, `irq_flag` is 0 and `evt_count` is 0.
- R2: `evt_sel` code 1 selects counter equal to zero, code 2 selects counter equal to `tb_prd`, and code 3 selects either of these. Codes 0 and 12 to 15 select no event, so the count never changes.
- R3: `evt_sel` codes 4/5, 6/7, 8/9 and 10/11 select a match with `cmp_a`, `cmp_b`, `cmp_c` and `cmp_d`. In each pair the even code counts only while `cnt_up` is 1 and the odd code counts only while `cnt_up` is 0.
- R4: An event counts once when the selected condition becomes true, however many clocks the condition stays true. The count is visible at `evt_count` one clock after the first clock in which the condition holds.
- R5: Each event raises `evt_count` by one until it equals the active period. With `irq_en` = 0 it then holds there, no matter how many more events arrive, and no pulse is produced.
- R6: When `evt_count` equals a nonzero active period, `irq_en` is 1 and `irq_flag` is 0, `irq_pulse` is 1 for exactly one clock on the next clock. In that same clock `irq_flag` becomes 1 and `evt_count` becomes 0.
- R7: An active period of 0 never produces a pulse, and the count stays 0.
- R8: With `ext_mode` = 0 the active period is `prd_legacy` (2 bits). With `ext_mode` = 1 it is `prd_ext` (4 bits), and `prd_legacy` is ignored.
- R9: While `irq_flag` is 1, a completed count holds at the period with no pulse. Once `flag_clr` clears the flag, the pending pulse fires one clock later.
- R10: If `flag_clr` is asserted in the clock in which a pulse is issued, `irq_flag` stays 1. An event arriving in that clock is not counted.
- R11: A `prd_wr` strobe whose active period is greater than `evt_count` clears `evt_count` to 0.
- R12: A `prd_wr` strobe whose active period equals `evt_count` issues a pulse on the next clock when `irq_en` is 1 and `irq_flag` is 0. The count is then cleared.
- R13: A `prd_wr` strobe whose active period is below `evt_count` leaves the count frozen at its value. Later events do not change it and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_cnt | input | CNT_W | Time-base counter value |
| tb_prd | input | CNT_W | Time-base period value |
| cmp_a | input | CNT_W | Compare value A |
| cmp_b | input | CNT_W | Compare value B |
| cmp_c | input | CNT_W | Compare value C |
| cmp_d | input | CNT_W | Compare value D |
| cnt_up | input | 1 | Time-base direction, 1 = counting up |
| evt_sel | input | 4 | Event source code (see R2, R3) |
| irq_en | input | 1 | Interrupt enable |
| ext_mode | input | 1 | 1 = 4-bit period format, 0 = 2-bit |
| prd_legacy | input | LEG_W | Short-format event period |
| prd_ext | input | EXT_W | Long-format event period |
| prd_wr | input | 1 | Strobe: period field written this clock |
| flag_clr | input | 1 | Strobe: clear the interrupt flag |
| irq_pulse | output | 1 | One-clock interrupt pulse |
| irq_flag | output | 1 | Sticky interrupt flag |
| evt_count | output | EXT_W | Current event count |

## Verification
The bench drives inputs and samples outputs on falling edges. An event condition presented for a clock shows up in `evt_count` at the next falling edge, because only the count register lies in between. The pulse, the flag and the count clear appear together one falling edge after the count first equals the period. A flag clear gives a clear flag one falling edge after the strobe and the pending pulse one edge after that. Each scenario task samples at exactly these edges, and a monitor counts pulses so that absent or extra pulses over long stretches are caught.

// File: rtl/etip_pkg.sv
package etip_pkg;

  localparam int unsigned SEL_W        = 4;
  localparam int unsigned NUM_CMP      = 4;
  localparam int unsigned SEL_CMP_BASE = 4;

  localparam logic [SEL_W-1:0] SEL_NONE     = 4'd0;
  localparam logic [SEL_W-1:0] SEL_ZERO     = 4'd1;
  localparam logic [SEL_W-1:0] SEL_PRD      = 4'd2;
  localparam logic [SEL_W-1:0] SEL_ZERO_PRD = 4'd3;

endpackage

// File: rtl/etip_event_select.sv
module etip_event_select
  import etip_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CMP = NUM_CMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tb_cnt,
  input  logic [CNT_W-1:0] tb_prd,
  input  logic [CNT_W-1:0] cmp_val [N_CMP],
  input  logic             cnt_up,
  input  logic [SEL_W-1:0] sel,
  output logic             evt
);

  logic [N_CMP-1:0] up_hit;
  logic [N_CMP-1:0] dn_hit;
  logic             is_zero;
  logic             is_prd;
  logic             match_d;
  logic             match_q;

  // per-compare direction-qualified matches
  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign up_hit[g] = (tb_cnt == cmp_val[g]) &&  cnt_up;
    assign dn_hit[g] = (tb_cnt == cmp_val[g]) && !cnt_up;
  end

  assign is_zero = (tb_cnt == '0);
  assign is_prd  = (tb_cnt == tb_prd);

  // source multiplexer
  always_comb begin
    match_d = 1'b0;
    case (sel)
      SEL_NONE:     match_d = 1'b0;
      SEL_ZERO:     match_d = is_zero;
      SEL_PRD:      match_d = is_prd;
      SEL_ZERO_PRD: match_d = is_zero || is_prd;
      default: begin
        for (int i = 0; i < int'(N_CMP); i++) begin
          if (sel == SEL_W'(SEL_CMP_BASE + 2*i))     match_d = up_hit[i];
          if (sel == SEL_W'(SEL_CMP_BASE + 2*i + 1)) match_d = dn_hit[i];
        end
      end
    endcase
  end

  // previous-match register for edge qualification
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
    end else begin
      match_q <= match_d;
    end
  end

  assign evt = match_d && !match_q;

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt); // R4

endmodule

// File: rtl/etip_period_mux.sv
module etip_period_mux #(
  parameter int unsigned LEG_W = 2,
  parameter int unsigned EXT_W = 4
) (
  input  logic             ext_mode,
  input  logic [LEG_W-1:0] prd_legacy,
  input  logic [EXT_W-1:0] prd_ext,
  output logic [EXT_W-1:0] prd
);

  always_comb begin
    if (ext_mode) prd = prd_ext;
    else          prd = EXT_W'(prd_legacy);
  end

endmodule

// File: rtl/etip_event_counter.sv
module etip_event_counter #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic [CW-1:0] prd,
  input  logic          prd_wr,
  input  logic          en,
  input  logic          flag_clr,
  output logic          pulse,
  output logic          flag,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          pulse_q, pulse_d;
  logic          fire;
  logic          wr_clear;
  logic          can_count;

  // next-state logic
  always_comb begin
    fire      = en && !flag_q && (prd != '0) && (cnt_q == prd);
    wr_clear  = prd_wr && (prd > cnt_q);
    can_count = evt && (cnt_q < prd);

    cnt_d = cnt_q;
    if (fire)           cnt_d = '0;
    else if (wr_clear)  cnt_d = '0;
    else if (can_count) cnt_d = cnt_q + CW'(1);

    flag_d = flag_q;
    if (fire)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;

    pulse_d = fire;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
  assign flag  = flag_q;
  assign cnt   = cnt_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R6
  AST_PULSE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (flag_q && cnt_q == '0)); // R6
  AST_PULSE_NEEDS_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> !$past(flag_q)); // R9
  AST_NO_PULSE_PRD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> ($past(prd) != '0)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + CW'(1))); // R5
  AST_STUCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > prd && !prd_wr) |=> ($stable(cnt_q) && !pulse_q)); // R13

endmodule

// File: rtl/etrig_irq_prescaler.sv
module etrig_irq_prescaler
  import etip_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LEG_W = 2,
  parameter int unsigned EXT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tb_cnt,
  input  logic [CNT_W-1:0] tb_prd,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] cmp_c,
  input  logic [CNT_W-1:0] cmp_d,
  input  logic             cnt_up,
  input  logic [SEL_W-1:0] evt_sel,
  input  logic             irq_en,
  input  logic             ext_mode,
  input  logic [LEG_W-1:0] prd_legacy,
  input  logic [EXT_W-1:0] prd_ext,
  input  logic             prd_wr,
  input  logic             flag_clr,
  output logic             irq_pulse,
  output logic             irq_flag,
  output logic [EXT_W-1:0] evt_count
);

  logic [CNT_W-1:0] cmp_arr [NUM_CMP];
  logic             evt;
  logic [EXT_W-1:0] prd_act;

  assign cmp_arr[0] = cmp_a;
  assign cmp_arr[1] = cmp_b;
  assign cmp_arr[2] = cmp_c;
  assign cmp_arr[3] = cmp_d;

  etip_event_select #(
    .CNT_W (CNT_W),
    .N_CMP (NUM_CMP)
  ) sel_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tb_cnt  (tb_cnt),
    .tb_prd  (tb_prd),
    .cmp_val (cmp_arr),
    .cnt_up  (cnt_up),
    .sel     (evt_sel),
    .evt     (evt)
  );

  etip_period_mux #(
    .LEG_W (LEG_W),
    .EXT_W (EXT_W)
  ) prd_i (
    .ext_mode   (ext_mode),
    .prd_legacy (prd_legacy),
    .prd_ext    (prd_ext),
    .prd        (prd_act)
  );

  etip_event_counter #(
    .CW (EXT_W)
  ) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .prd      (prd_act),
    .prd_wr   (prd_wr),
    .en       (irq_en),
    .flag_clr (flag_clr),
    .pulse    (irq_pulse),
    .flag     (irq_flag),
    .cnt      (evt_count)
  );

  AST_FLAG_HOLD_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && $past(flag_clr)) |-> irq_flag); // R10

endmodule

// File: tb/etrig_irq_prescaler_tb_top.sv
module etrig_irq_prescaler_tb_top;

  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] IDLE = 16'd50;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] tb_cnt, tb_prd, cmp_a, cmp_b, cmp_c, cmp_d;
  logic             cnt_up;
  logic [3:0]       evt_sel;
  logic             irq_en, ext_mode, prd_wr, flag_clr;
  logic [1:0]       prd_legacy;
  logic [3:0]       prd_ext;
  logic             irq_pulse, irq_flag;
  logic [3:0]       evt_count;

  int checks = 0;
  int failures = 0;
  int pulses_seen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  etrig_irq_prescaler dut_i (
    .clk(clk), .rst_n(rst_n), .tb_cnt(tb_cnt), .tb_prd(tb_prd),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .cmp_d(cmp_d),
    .cnt_up(cnt_up), .evt_sel(evt_sel), .irq_en(irq_en), .ext_mode(ext_mode),
    .prd_legacy(prd_legacy), .prd_ext(prd_ext), .prd_wr(prd_wr),
    .flag_clr(flag_clr), .irq_pulse(irq_pulse), .irq_flag(irq_flag),
    .evt_count(evt_count)
  );

  always @(posedge clk) if (rst_n && irq_pulse) pulses_seen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tb_cnt = IDLE; tb_prd = 16'd100;
    cmp_a = 16'd10; cmp_b = 16'd20; cmp_c = 16'd30; cmp_d = 16'd40;
    cnt_up = 1'b1; evt_sel = 4'd1; irq_en = 1'b0; ext_mode = 1'b0;
    prd_legacy = 2'd0; prd_ext = 4'd0; prd_wr = 1'b0; flag_clr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ev(input logic [CNT_W-1:0] val);
    @(negedge clk) tb_cnt = val;
    @(negedge clk) tb_cnt = IDLE;
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic write_prd(input logic [3:0] p);
    @(negedge clk) begin prd_ext = p; prd_wr = 1'b1; end
    @(negedge clk) prd_wr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 pulse in reset", irq_pulse, 0);
    chk("R1 flag in reset", irq_flag, 0);
    chk("R1 count in reset", evt_count, 0);
    do_reset();
    chk("R1 count after reset", evt_count, 0);
  endtask

  task automatic t_select();
    int base;
    do_reset();
    ext_mode = 1'b1; prd_ext = 4'd15;
    evt_sel = 4'd1; base = evt_count; ev(0); ev(100);
    chk("R2 zero select", evt_count - base, 1);
    evt_sel = 4'd2; base = evt_count; ev(100); ev(0);
    chk("R2 period select", evt_count - base, 1);
    evt_sel = 4'd3; base = evt_count; ev(0); ev(100);
    chk("R2 zero-or-period select", evt_count - base, 2);
    evt_sel = 4'd13; base = evt_count; ev(0); ev(100); ev(10);
    chk("R2 unused code", evt_count - base, 0);
    evt_sel = 4'd0; base = evt_count; ev(0); ev(100);
    chk("R2 code zero", evt_count - base, 0);
    do_reset();
    ext_mode = 1'b1; prd_ext = 4'd15;
    evt_sel = 4'd4; cnt_up = 1'b1; ev(10);
    chk("R3 A up while up", evt_count, 1);
    cnt_up = 1'b0; ev(10);
    chk("R3 A up while down", evt_count, 1);
    evt_sel = 4'd7; ev(20);
    chk("R3 B down while down", evt_count, 2);
    cnt_up = 1'b1; ev(20);
    chk("R3 B down while up", evt_count, 2);
    cnt_up = 1'b0; evt_sel = 4'd9; ev(30);
    chk("R3 C down", evt_count, 3);
    cnt_up = 1'b1; evt_sel = 4'd10; ev(40); ev(30);
    chk("R3 D up only on D", evt_count, 4);
  endtask

  task automatic t_edge();
    do_reset();
    evt_sel = 4'd1; ext_mode = 1'b1; prd_ext = 4'd15;
    @(negedge clk) tb_cnt = 0;
    repeat (5) @(negedge clk);
    tb_cnt = IDLE;
    @(negedge clk);
    chk("R4 held match counts once", evt_count, 1);
    ev(0);
    chk("R4 new match counts", evt_count, 2);
  endtask

  task automatic t_sat_coincide();
    int p0;
    do_reset();
    prd_legacy = 2'd2;
    p0 = pulses_seen;
    ev(0); ev(0); ev(0); ev(0);
    @(negedge clk);
    chk("R5 saturates at period", evt_count, 2);
    chk("R5 no pulse when disabled", pulses_seen - p0, 0);
    @(negedge clk) begin irq_en = 1'b1; flag_clr = 1'b1; tb_cnt = 0; end
    @(negedge clk);
    chk("R10 pulse issued", irq_pulse, 1);
    chk("R10 flag kept set", irq_flag, 1);
    chk("R10 count cleared", evt_count, 0);
    flag_clr = 1'b0; tb_cnt = IDLE;
    @(negedge clk);
    chk("R10 event not counted", evt_count, 0);
  endtask

  task automatic t_fire();
    do_reset();
    irq_en = 1'b1; prd_legacy = 2'd3;
    ev(0); ev(0);
    chk("R6 count before period", evt_count, 2);
    chk("R6 no early pulse", irq_pulse, 0);
    ev(0);
    chk("R6 count at period", evt_count, 3);
    chk("R6 pulse not yet", irq_pulse, 0);
    @(negedge clk);
    chk("R6 pulse high", irq_pulse, 1);
    chk("R6 flag set", irq_flag, 1);
    chk("R6 count cleared", evt_count, 0);
    @(negedge clk);
    chk("R6 pulse one cycle", irq_pulse, 0);
  endtask

  task automatic t_prd0();
    int p0;
    do_reset();
    irq_en = 1'b1; prd_legacy = 2'd0;
    p0 = pulses_seen;
    ev(0); ev(0); ev(0); ev(0);
    repeat (3) @(negedge clk);
    chk("R7 count stays zero", evt_count, 0);
    chk("R7 never pulses", pulses_seen - p0, 0);
  endtask

  task automatic t_ext();
    int p0;
    do_reset();
    irq_en = 1'b1; ext_mode = 1'b1; prd_ext = 4'd5; prd_legacy = 2'd3;
    p0 = pulses_seen;
    repeat (4) ev(0);
    @(negedge clk);
    chk("R8 short field ignored", pulses_seen - p0, 0);
    chk("R8 count at four", evt_count, 4);
    ev(0);
    repeat (2) @(negedge clk);
    chk("R8 pulse on fifth", pulses_seen - p0, 1);
    chk("R8 count cleared", evt_count, 0);
  endtask

  task automatic t_pending();
    int p0;
    do_reset();
    irq_en = 1'b1; prd_legacy = 2'd1;
    ev(0);
    @(negedge clk);
    chk("R9 first pulse", irq_pulse, 1);
    ev(0);
    p0 = pulses_seen;
    repeat (4) @(negedge clk);
    chk("R9 held at period", evt_count, 1);
    chk("R9 no pulse while flagged", pulses_seen - p0, 0);
    clear_flag();
    chk("R9 flag cleared", irq_flag, 0);
    chk("R9 pulse not yet", irq_pulse, 0);
    @(negedge clk);
    chk("R9 pending pulse", irq_pulse, 1);
    chk("R9 flag set again", irq_flag, 1);
    chk("R9 count cleared", evt_count, 0);
  endtask

  task automatic t_prdwr();
    int p0;
    do_reset();
    irq_en = 1'b1; ext_mode = 1'b1; prd_ext = 4'd8;
    repeat (3) ev(0);
    chk("R11 count three", evt_count, 3);
    write_prd(4'd10);
    chk("R11 larger write clears", evt_count, 0);
    repeat (3) ev(0);
    write_prd(4'd3);
    chk("R12 equal write pulse", irq_pulse, 1);
    chk("R12 equal write clears", evt_count, 0);
    clear_flag();
    write_prd(4'd8);
    repeat (3) ev(0);
    write_prd(4'd2);
    chk("R13 stuck value", evt_count, 3);
    p0 = pulses_seen;
    repeat (3) ev(0);
    repeat (2) @(negedge clk);
    chk("R13 events ignored", evt_count, 3);
    chk("R13 no pulse", pulses_seen - p0, 0);
    chk("R13 flag clear", irq_flag, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset();
    t_reset();
    t_select();
    t_edge();
    t_sat_coincide();
    t_fire();
    t_prd0();
    t_ext();
    t_pending();
    t_prdwr();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule